// File: doc/BRIEF.md
# 16-bit Register-Machine Core

This block is a small in-order processor for a compact 16-bit instruction set. It holds sixteen 16-bit registers and talks to a single word-organised memory that stores both program and data. Each instruction is fetched, decoded and executed before the next fetch begins. Instructions are few: subtract, immediate low and high loads, shift left or right by one, four register-indirect conditional jumps, load, and store.

Register 0 is special. It always reads as zero. A write to it changes no register and sends the low byte of the result out on a character port, together with a one-cycle strobe. Program counter and data addresses are byte addresses. The memory is addressed by word, so the core drives the byte address shifted right by one. Memory reads are synchronous, and read data returns one cycle after the address. Any word that decodes to no instruction stops the core for good, and a sticky halted flag is raised. A count of retired instructions is brought out for verification.

Top module: `tiny16_core`

## Requirements
- R1: While reset is held, and in the cycle it is released, `halted`, `retired`, `char_valid` and `mem_we` are zero and `mem_addr` is zero. Execution starts at byte address 0.
- R2: Instruction fields are ra = bits 11:8, rb = bits 7:4 and rt = bits 3:0. When bits 15:12 are 0000, rt receives (ra - rb) mod 2^16.
- R3: When bits 15:12 are 1000, rt receives the immediate in bits 11:4, sign-extended to 16 bits. When bits 15:12 are 1001, rt keeps its low byte and its high byte becomes the immediate.
- R4: When bits 15:12 are 0001, bits 7:4 = 0000 writes ra shifted right by one (a zero enters at the top) into rt. Bits 7:4 = 0001 writes ra shifted left by one, truncated to 16 bits, into rt.
- R5: When bits 15:12 are 1110 and bits 7:6 are 00, the instruction is a jump. Its condition comes from bits 5:4: 00 means ra is zero, 01 means ra is nonzero, 10 means ra bit 15 is set, and 11 means ra bit 15 is clear. When the condition holds, the PC becomes the value of rt. Otherwise the PC advances by 2, as it does after every other instruction.
- R6: When bits 15:12 are 1111, bits 7:4 = 0000 loads the memory word at the address in ra into rt. Bits 7:4 = 0001 stores rt at the address in ra. Memory is accessed at word index (byte address >> 1), so bit 0 of the address is ignored.
- R7: Register 0 reads as zero. A write to register 0 changes no register and pulses `char_valid` high for exactly one cycle, with `char_data` equal to the low 8 bits of the result.
- R8: A word that matches no instruction is not executed. It raises `halted`, which then stays high. After that there are no further register writes, characters, stores or retirements.
- R9: `retired` increases by exactly one for each executed instruction and does not change otherwise.
- R10: Register writes, characters and stores take effect in program order, so a load that follows a store to the same word returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Word address to memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after its address |
| char_valid | output | 1 | One-cycle strobe for an emitted character |
| char_data | output | 8 | Emitted character byte |
| halted | output | 1 | Sticky stop flag |
| retired | output | CNT_W | Count of executed instructions |

## Verification
The assertions assume that memory returns the addressed word exactly one cycle after the address is driven. They also assume that no other agent writes memory while the core runs. The bench memory model registers its read data on every clock edge and is written only through the core's store port once reset is released. Programs are loaded only while reset is held. Every program word is built with encoder helpers, and all data addresses fall inside the bench's 256-word memory. Each program ends on a deliberately undecodable word, which keeps runs finite.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

  typedef enum logic [3:0] {
    K_SUB, K_MOVL, K_MOVH, K_SHR, K_SHL, K_JMP, K_LD, K_ST, K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_LWAIT, S_HALT
  } phase_e;

  typedef struct packed {
    kind_e       kind;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [3:0]  rt;
    logic [7:0]  imm;
    logic [1:0]  cond;
  } dec_t;

  // Instruction classification; anything unmatched is K_BAD.
  function automatic dec_t decode(input logic [15:0] w);
    dec_t d;
    d.ra   = w[11:8];
    d.rb   = w[7:4];
    d.rt   = w[3:0];
    d.imm  = w[11:4];
    d.cond = w[5:4];
    case (w[15:12])
      4'h0:    d.kind = K_SUB;
      4'h1:    d.kind = (w[7:4] == 4'h0) ? K_SHR : (w[7:4] == 4'h1) ? K_SHL : K_BAD;
      4'h8:    d.kind = K_MOVL;
      4'h9:    d.kind = K_MOVH;
      4'hE:    d.kind = (w[7:6] == 2'b00) ? K_JMP : K_BAD;
      4'hF:    d.kind = (w[7:4] == 4'h0) ? K_LD : (w[7:4] == 4'h1) ? K_ST : K_BAD;
      default: d.kind = K_BAD;
    endcase
    return d;
  endfunction

  // Register result of the arithmetic and move instructions.
  function automatic logic [15:0] compute(input kind_e k, input logic [15:0] a,
                                          input logic [15:0] b, input logic [15:0] t,
                                          input logic [7:0] imm);
    case (k)
      K_SUB:   return a - b;
      K_MOVL:  return {{8{imm[7]}}, imm};
      K_MOVH:  return {imm, t[7:0]};
      K_SHR:   return {1'b0, a[15:1]};
      K_SHL:   return {a[14:0], 1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic cond_met(input logic [1:0] c, input logic [15:0] a);
    case (c)
      2'b00:   return a == 16'h0000;
      2'b01:   return a != 16'h0000;
      2'b10:   return a[15];
      default: return !a[15];
    endcase
  endfunction

endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
  import tiny16_pkg::*;
(
  input  logic [15:0] word,
  output dec_t        dec
);
  assign dec = decode(word);
endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
  parameter int NREG = 16,
  parameter int W    = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx_a,
  input  logic [IW-1:0] ridx_b,
  input  logic [IW-1:0] ridx_t,
  output logic [W-1:0]  a,
  output logic [W-1:0]  b,
  output logic [W-1:0]  t
);
  // Entry 0 has no storage: regs[k] holds register k+1.
  logic [W-1:0] regs [NREG-1];

  always_ff @(posedge clk) begin
    for (int i = 1; i < NREG; i++) begin
      if (!rst_n)
        regs[i-1] <= '0;
      else if (we && widx == IW'(i))
        regs[i-1] <= wdata;
    end
  end

  assign a = (ridx_a == '0) ? '0 : regs[ridx_a - 1'b1];
  assign b = (ridx_b == '0) ? '0 : regs[ridx_b - 1'b1];
  assign t = (ridx_t == '0) ? '0 : regs[ridx_t - 1'b1];
endmodule

// File: rtl/tiny16_exec.sv
module tiny16_exec
  import tiny16_pkg::*;
(
  input  dec_t        dec,
  input  logic [15:0] a_val,
  input  logic [15:0] b_val,
  input  logic [15:0] t_val,
  input  logic [15:0] pc,
  output logic [15:0] result,
  output logic        writes_reg,
  output logic        taken,
  output logic [15:0] next_pc
);
  assign result     = compute(dec.kind, a_val, b_val, t_val, dec.imm);
  assign writes_reg = dec.kind inside {K_SUB, K_MOVL, K_MOVH, K_SHR, K_SHL};
  assign taken      = (dec.kind == K_JMP) && cond_met(dec.cond, a_val);
  assign next_pc    = taken ? t_val : pc + 16'd2;
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int AW    = 15,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  output logic             char_valid,
  output logic [7:0]       char_data,
  output logic             halted,
  output logic [CNT_W-1:0] retired
);
  phase_e      phase;
  logic [15:0] pc, ir;
  dec_t        dec;
  logic [15:0] a_val, b_val, t_val, result, next_pc;
  logic        writes_reg, taken;

  // Named events, also observed by the checker.
  logic        exec_fire, bad_fire, load_issue, load_done, retire_evt;
  logic        jump_taken, wr_en, char_evt;
  logic [15:0] wr_data, sel_addr, shifted;
  logic        unused_addr;

  tiny16_decode u_dec (.word(ir), .dec(dec));

  tiny16_regfile #(.NREG(16), .W(16)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(dec.rt), .wdata(wr_data),
    .ridx_a(dec.ra), .ridx_b(dec.rb), .ridx_t(dec.rt),
    .a(a_val), .b(b_val), .t(t_val)
  );

  tiny16_exec u_exec (
    .dec(dec), .a_val(a_val), .b_val(b_val), .t_val(t_val), .pc(pc),
    .result(result), .writes_reg(writes_reg), .taken(taken), .next_pc(next_pc)
  );

  assign exec_fire  = (phase == S_EXEC) && (dec.kind != K_BAD);
  assign bad_fire   = (phase == S_EXEC) && (dec.kind == K_BAD);
  assign load_issue = exec_fire && (dec.kind == K_LD);
  assign load_done  = (phase == S_LWAIT);
  assign retire_evt = (exec_fire && dec.kind != K_LD) || load_done;
  assign jump_taken = exec_fire && taken;
  assign wr_en      = (exec_fire && writes_reg) || load_done;
  assign wr_data    = load_done ? mem_rdata : result;
  assign char_evt   = wr_en && (dec.rt == 4'h0);

  // Byte address to word index.
  assign sel_addr    = (exec_fire && (dec.kind == K_LD || dec.kind == K_ST)) ? a_val : pc;
  assign shifted     = sel_addr >> 1;
  assign mem_addr    = shifted[AW-1:0];
  assign unused_addr = ^{sel_addr[0], shifted};
  assign mem_we      = exec_fire && (dec.kind == K_ST);
  assign mem_wdata   = t_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= S_FETCH;
      pc         <= '0;
      ir         <= '0;
      halted     <= 1'b0;
      retired    <= '0;
      char_valid <= 1'b0;
      char_data  <= '0;
    end else begin
      char_valid <= char_evt;
      if (char_evt) char_data <= wr_data[7:0];
      if (retire_evt) begin
        pc      <= next_pc;
        retired <= retired + CNT_W'(1);
      end
      case (phase)
        S_FETCH:  phase <= S_DECODE;
        S_DECODE: begin
          ir    <= mem_rdata;
          phase <= S_EXEC;
        end
        S_EXEC: begin
          if (bad_fire) begin
            halted <= 1'b1;
            phase  <= S_HALT;
          end else if (load_issue) begin
            phase <= S_LWAIT;
          end else begin
            phase <= S_FETCH;
          end
        end
        S_LWAIT:  phase <= S_FETCH;
        default:  phase <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halted,
  input logic             mem_we,
  input logic             char_valid,
  input logic [CNT_W-1:0] retired,
  input logic             retire_evt,
  input logic             jump_taken,
  input logic [15:0]      t_val,
  input logic [15:0]      pc,
  input logic             load_issue,
  input logic             load_done,
  input logic             bad_fire
);
  assert_char_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !char_valid && !retire_evt));

  assert_halt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> (halted && retired == $past(retired)));

  assert_retire_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |=> retired == $past(retired) + CNT_W'(1));

  assert_retire_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_evt |=> retired == $past(retired));

  assert_pc_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_evt && !jump_taken) |=> pc == $past(pc) + 16'd2);

  assert_pc_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> pc == $past(t_val));

  assert_load_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_issue |=> load_done);
endmodule

bind tiny16_core tiny16_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_we(mem_we),
  .char_valid(char_valid), .retired(retired), .retire_evt(retire_evt),
  .jump_taken(jump_taken), .t_val(t_val), .pc(pc), .load_issue(load_issue),
  .load_done(load_done), .bad_fire(bad_fire)
);

// File: tb/tiny16_core_bench.sv
module tiny16_core_bench;
  localparam int AW = 8;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          char_valid;
  logic [7:0]    char_data;
  logic          halted;
  logic [31:0]   retired;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mem  [MW];
  logic [15:0] refm [MW];
  logic [7:0]  exp_q[$];
  int          exp_ret;
  int          chars_seen;

  always #5 clk = ~clk;

  tiny16_core #(.AW(AW), .CNT_W(32)) u_tiny16_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .char_valid(char_valid),
    .char_data(char_data), .halted(halted), .retired(retired)
  );

  // Synchronous memory: read data one cycle after address.
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: characters in order (R7, R10); nothing after halt (R8).
  always @(negedge clk) begin
    if (rst_n && char_valid) begin
      chars_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R7/R8 unexpected character", {24'h0, char_data}, 32'h0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(char_data == e, "R7 character value", {24'h0, char_data}, {24'h0, e});
      end
    end
    if (rst_n && halted && mem_we)
      chk(0, "R8 store after halt", 32'h1, 32'h0);
  end

  // Encoders
  function automatic logic [15:0] e_sub(input logic [3:0] t, input logic [3:0] a, input logic [3:0] b);
    return {4'h0, a, b, t};
  endfunction
  function automatic logic [15:0] e_movl(input logic [3:0] t, input logic [7:0] i);
    return {4'h8, i, t};
  endfunction
  function automatic logic [15:0] e_movh(input logic [3:0] t, input logic [7:0] i);
    return {4'h9, i, t};
  endfunction
  function automatic logic [15:0] e_shr(input logic [3:0] t, input logic [3:0] a);
    return {4'h1, a, 4'h0, t};
  endfunction
  function automatic logic [15:0] e_shl(input logic [3:0] t, input logic [3:0] a);
    return {4'h1, a, 4'h1, t};
  endfunction
  function automatic logic [15:0] e_jmp(input logic [1:0] c, input logic [3:0] t, input logic [3:0] a);
    return {4'hE, a, 2'b00, c, t};
  endfunction
  function automatic logic [15:0] e_ld(input logic [3:0] t, input logic [3:0] a);
    return {4'hF, a, 4'h0, t};
  endfunction
  function automatic logic [15:0] e_st(input logic [3:0] t, input logic [3:0] a);
    return {4'hF, a, 4'h1, t};
  endfunction

  // Independent reference interpreter built from the requirement text.
  task automatic run_model();
    logic [15:0] r [16];
    logic [15:0] p, w, va, vb, vt, res;
    bit wr, stop;
    for (int i = 0; i < 16; i++) r[i] = '0;
    for (int i = 0; i < MW; i++) refm[i] = mem[i];
    p = '0; exp_ret = 0; stop = 0;
    for (int n = 0; n < 5000 && !stop; n++) begin
      w  = refm[(p >> 1) % MW];
      va = (w[11:8] == 0) ? 16'h0 : r[w[11:8]];
      vb = (w[7:4]  == 0) ? 16'h0 : r[w[7:4]];
      vt = (w[3:0]  == 0) ? 16'h0 : r[w[3:0]];
      wr = 1; res = '0;
      if (w[15:12] == 4'b0000) res = va + ~vb + 16'd1;
      else if (w[15:12] == 4'b1000) res = 16'(signed'(w[11:4]));
      else if (w[15:12] == 4'b1001) res = (vt & 16'h00FF) | (16'(w[11:4]) << 8);
      else if (w[15:12] == 4'b0001 && w[7:4] == 4'd0) res = va / 2;
      else if (w[15:12] == 4'b0001 && w[7:4] == 4'd1) res = 16'(va * 2);
      else if (w[15:12] == 4'b1111 && w[7:4] == 4'd0) res = refm[(va >> 1) % MW];
      else if (w[15:12] == 4'b1111 && w[7:4] == 4'd1) begin
        refm[(va >> 1) % MW] = vt; wr = 0;
      end else if (w[15:12] == 4'b1110 && w[7:6] == 2'b00) begin
        bit go;
        wr = 0;
        go = (w[5:4] == 0) ? (va == 0) : (w[5:4] == 1) ? (va != 0) :
             (w[5:4] == 2) ? (va >= 16'h8000) : (va < 16'h8000);
        if (go) p = vt - 16'd2;
      end else stop = 1;
      if (!stop) begin
        if (wr) begin
          if (w[3:0] == 0) exp_q.push_back(res[7:0]);
          else r[w[3:0]] = res;
        end
        p = p + 16'd2;
        exp_ret++;
      end
    end
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(halted == 0,     "R1 halted in reset", {31'h0, halted}, 32'h0);
    chk(retired == 0,    "R1 retired in reset", retired, 32'h0);
    chk(char_valid == 0, "R1 char_valid in reset", {31'h0, char_valid}, 32'h0);
    chk(mem_we == 0,     "R1 mem_we in reset", {31'h0, mem_we}, 32'h0);
    chk(mem_addr == 0,   "R1 mem_addr in reset", {24'h0, mem_addr}, 32'h0);
  endtask

  // Driver: model fills the scoreboard, then the core runs until it halts.
  task automatic run_prog(input string name, input int hand_ret, input int hand_chars);
    int r0;
    exp_q.delete();
    run_model();
    chars_seen = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 20000 && !halted; c++) @(negedge clk);
    chk(halted == 1, "R8 halted reached", {31'h0, halted}, 32'h1);
    r0 = retired;
    repeat (20) @(negedge clk);
    chk(retired == r0, "R8 retired frozen after halt", retired, r0);
    chk(retired == exp_ret, "R9 retired vs model", retired, exp_ret);
    chk(retired == hand_ret, "R9 retired hand count", retired, hand_ret);
    chk(exp_q.size() == 0, "R7 all expected characters seen", exp_q.size(), 0);
    chk(chars_seen == hand_chars, "R7/R8 character count", chars_seen, hand_chars);
    for (int i = 0; i < MW; i++)
      if (mem[i] !== refm[i]) chk(0, "R6 memory vs model", mem[i], refm[i]);
    checks++;
    $display("program %s done", name);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Program 1: arithmetic, moves, shifts, load/store (R2 R3 R4 R6 R7 R10)
    reset_and_check();
    for (int i = 0; i < MW; i++) mem[i] = 16'h2000;
    mem[0]  = e_movl(1, 8'h48);
    mem[1]  = e_sub(0, 1, 0);
    mem[2]  = e_movl(2, 8'hF0);
    mem[3]  = e_movl(5, 8'h40);
    mem[4]  = e_st(2, 5);
    mem[5]  = e_movh(2, 8'h12);
    mem[6]  = e_movl(6, 8'h42);
    mem[7]  = e_st(2, 6);
    mem[8]  = e_shl(3, 2);
    mem[9]  = e_movl(7, 8'h44);
    mem[10] = e_st(3, 7);
    mem[11] = e_movl(8, 8'h01);
    mem[12] = e_movh(8, 8'h80);
    mem[13] = e_shl(9, 8);
    mem[14] = e_shr(10, 8);
    mem[15] = e_movl(11, 8'h46);
    mem[16] = e_st(9, 11);
    mem[17] = e_movl(12, 8'h48);
    mem[18] = e_st(10, 12);
    mem[19] = e_ld(13, 6);
    mem[20] = e_sub(0, 13, 0);
    mem[21] = e_movl(3, 8'h43);
    mem[22] = e_ld(4, 3);
    mem[23] = e_sub(0, 4, 0);
    mem[24] = e_sub(14, 0, 1);
    mem[25] = e_movl(15, 8'h4A);
    mem[26] = e_st(14, 15);
    mem[27] = 16'h2000;
    mem[28] = e_movl(0, 8'h21);
    run_prog("arith", 27, 3);
    chk(mem[32] == 16'hFFF0, "R3 movl sign extension", mem[32], 16'hFFF0);
    chk(mem[33] == 16'h12F0, "R3 movh keeps low byte", mem[33], 16'h12F0);
    chk(mem[34] == 16'h25E0, "R4 shift left", mem[34], 16'h25E0);
    chk(mem[35] == 16'h0002, "R4 shift left truncates", mem[35], 16'h0002);
    chk(mem[36] == 16'h4000, "R4 shift right logical", mem[36], 16'h4000);
    chk(mem[37] == 16'hFFB8, "R2 subtract wraps, R7 r0 reads zero", mem[37], 16'hFFB8);

    // Program 2: all four jump conditions, taken and not taken (R5)
    reset_and_check();
    for (int i = 0; i < MW; i++) mem[i] = 16'h2000;
    mem[0]  = e_movl(1, 8'h03);
    mem[1]  = e_movl(2, 8'h01);
    mem[2]  = e_movl(7, 8'h08);
    mem[3]  = e_movl(12, 8'h00);
    mem[4]  = e_sub(0, 1, 0);
    mem[5]  = e_sub(1, 1, 2);
    mem[6]  = e_jmp(2'b01, 7, 1);
    mem[7]  = e_movl(8, 8'hFF);
    mem[8]  = e_movl(9, 8'h16);
    mem[9]  = e_jmp(2'b10, 9, 8);
    mem[10] = e_movl(0, 8'hEE);
    mem[11] = e_jmp(2'b11, 9, 8);
    mem[12] = e_movl(0, 8'h55);
    mem[13] = e_movl(10, 8'h20);
    mem[14] = e_jmp(2'b00, 10, 0);
    mem[15] = e_movl(0, 8'hEE);
    mem[16] = e_movl(11, 8'h2A);
    mem[17] = e_jmp(2'b00, 10, 2);
    mem[18] = e_jmp(2'b01, 10, 0);
    mem[19] = e_jmp(2'b11, 11, 2);
    mem[20] = e_movl(0, 8'hEE);
    mem[21] = e_movl(0, 8'h77);
    mem[22] = 16'h1020;
    mem[23] = e_movl(0, 8'h33);
    run_prog("jumps", 25, 5);

    // Program 3: jump-like word with bit 6 set halts without executing (R8)
    reset_and_check();
    for (int i = 0; i < MW; i++) mem[i] = 16'h2000;
    mem[0] = e_movl(0, 8'h41);
    mem[1] = 16'hE040;
    mem[2] = e_movl(0, 8'h42);
    run_prog("halt", 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule